// File: doc/BRIEF.md
# Reset and Stop-Recovery Sequencer

This block decides when the CPU and the rest of a small 8-bit controller are held in reset and when they are released. It takes the board-level reset line, which it both reads and can pull low, together with the internal reset requests from the power-on detector, the brown-out detector, the watchdog and the debugger. It also takes a wake event that ends stop mode, and a flag that says whether the crystal oscillator is in use.

Short glitches on the reset line are rejected by counting consecutive low cycles after a two-stage synchronizer. An internally caused system reset pulls the shared line low for the whole reset period, so that other parts on the board are reset along with the controller. A single counter times both the system reset period and the stop-recovery delay. The stop-recovery delay is short when the internal oscillator is the only clock source and long when the crystal has to settle. On every release, a one-cycle request asks the CPU to fetch its reset vector. A small cause register, cleared when read, tells software why the last reset happened.

Top module: `rstseq_top`

## Requirements
- R1: A reset-line low level seen for 4 or more consecutive synchronized cycles starts a system reset and sets the cause field to 3'b001. A low level of 3 or fewer cycles is ignored: `cpu_rst_o` stays low and `stat_o` keeps its value.
- R2: A system reset that is not extended by the reset line holds `cpu_rst_o` and `sys_rst_o` high for exactly RST_CYC (default 66) cycles.
- R3: If the reset line is still low when the system reset period ends, reset stays asserted without driving the pin. `cpu_rst_o` falls on the third clock edge after the line returns high: two synchronizer stages, then one state update.
- R4: For a reset caused by power-on, brown-out, watchdog or debugger, `pin_drive_o` is high in every cycle of the reset. For resets caused by the line itself or by stop recovery, `pin_drive_o` stays low.
- R5: The cause field `stat_o` has bit 0 for the external line, bit 1 for power-on class (power-on, brown-out, debugger) and bit 2 for stop recovery. At most one bit is set. A watchdog-only reset leaves 3'b000.
- R6: When several internal requests arrive in the same cycle, the power-on class wins and `stat_o` becomes 3'b010.
- R7: A debugger request makes `dbg_clr_o` high in the first cycle of the resulting reset, so the request bit can clear itself. Afterwards the power-on bit reads as set.
- R8: A stop wake holds `cpu_rst_o` high for STOP_IPO_CYC (66) cycles when `xtal_en_i` is low, or STOP_XTAL_CYC (5000) cycles when it is high. During this time `sys_rst_o` and `pin_drive_o` stay low and `stat_o` reads 3'b100.
- R9: `osc_force_int_o` is high in every cycle in which `cpu_rst_o` is high.
- R10: `vec_fetch_o` is a single-cycle pulse in the first cycle after `cpu_rst_o` falls.
- R11: A `stat_rd_i` pulse while the CPU runs clears `stat_o` to 3'b000 on the next edge.
- R12: While `rst_n` is low, the block sits in system reset with `stat_o` = 3'b010 and the pin driven. After `rst_n` rises, it releases after RST_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer itself |
| pin_rst_n_i | input | 1 | Level read back from the shared reset line (asynchronous) |
| por_req_i | input | 1 | Power-on reset request |
| bo_req_i | input | 1 | Brown-out reset request |
| wdt_req_i | input | 1 | Watchdog reset request |
| dbg_req_i | input | 1 | Debugger reset request bit |
| stop_wake_i | input | 1 | Stop-mode wake event |
| xtal_en_i | input | 1 | Crystal oscillator enabled |
| stat_rd_i | input | 1 | Read strobe of the cause register (clears it) |
| cpu_rst_o | output | 1 | CPU held in reset |
| sys_rst_o | output | 1 | Reset for all logic except the debugger |
| pin_drive_o | output | 1 | Open-drain enable, 1 pulls the reset line low |
| osc_force_int_o | output | 1 | Forces the internal oscillator on and selected; also resets watchdog and oscillator control |
| vec_fetch_o | output | 1 | Request to fetch the reset vector |
| dbg_clr_o | output | 1 | Clears the debugger reset-request bit |
| stat_o | output | 3 | Reset cause: bit 0 external, bit 1 power-on class, bit 2 stop |

## Verification
The assertions check, on every cycle, the relations between outputs:
- the pin is driven only inside a system reset;
- the vector request is a lone pulse that follows every release;
- the cause field is never multi-hot;
- a stop recovery never overruns its longest delay and shows the stop cause throughout.

The scenarios cover the behaviour that depends on counts and history: the exact reset lengths for each cause and crystal setting, the edge between a rejected 3-cycle glitch and an accepted 4-cycle low, the extension while the line stays low, cause priority, and clear on read.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int STAT_W = 3;

  localparam logic [STAT_W-1:0] CAUSE_EXT  = 3'b001;
  localparam logic [STAT_W-1:0] CAUSE_POR  = 3'b010;
  localparam logic [STAT_W-1:0] CAUSE_STOP = 3'b100;

  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_SYSRST  = 2'd1,
    ST_HOLD    = 2'd2,
    ST_STOPREC = 2'd3
  } seq_st_t;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = d_i;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  // idle level of the line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_lowfilt.sv
module rstseq_lowfilt #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lvl_i,
  output logic trig_o
);

  localparam int            CW   = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

  logic [CW-1:0] low_q;
  logic [CW-1:0] low_d;

  always_comb begin
    low_d = low_q;
    if (!en_i || lvl_i)   low_d = '0;
    else if (low_q != LAST) low_d = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  // fires on the MIN_LOW-th consecutive low sample
  assign trig_o = en_i && !lvl_i && (low_q == LAST);

endmodule

// File: rtl/rstseq_delay.sv
module rstseq_delay #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = en_i && (cnt_q == limit_i - CW'(1));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FILT_MIN      = 4,
  parameter int RST_CYC       = 66,
  parameter int STOP_IPO_CYC  = 66,
  parameter int STOP_XTAL_CYC = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_rst_n_i,
  input  logic              por_req_i,
  input  logic              bo_req_i,
  input  logic              wdt_req_i,
  input  logic              dbg_req_i,
  input  logic              stop_wake_i,
  input  logic              xtal_en_i,
  input  logic              stat_rd_i,
  output logic              cpu_rst_o,
  output logic              sys_rst_o,
  output logic              pin_drive_o,
  output logic              osc_force_int_o,
  output logic              vec_fetch_o,
  output logic              dbg_clr_o,
  output logic [STAT_W-1:0] stat_o
);

  localparam int MAX_A   = (RST_CYC > STOP_IPO_CYC) ? RST_CYC : STOP_IPO_CYC;
  localparam int MAX_CYC = (MAX_A > STOP_XTAL_CYC) ? MAX_A : STOP_XTAL_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  seq_st_t           st_q, st_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              drv_q, drv_d;
  logic              dbgclr_q, dbgclr_d;
  logic              vf_q, vf_d;
  logic              xtal_q, xtal_d;

  logic              pin_s;
  logic              filt_en, ext_trig;
  logic              cnt_clr, cnt_en, cnt_done;
  logic [CW-1:0]     cnt_limit;
  logic              por_any, dbg_ok, int_req;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_rst_n_i),
    .q_o   (pin_s)
  );

  // the line is only watched while this block is not driving it
  assign filt_en = (st_q == ST_RUN) || (st_q == ST_STOPREC);

  rstseq_lowfilt #(.MIN_LOW(FILT_MIN)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (filt_en),
    .lvl_i  (pin_s),
    .trig_o (ext_trig)
  );

  assign cnt_en    = (st_q == ST_SYSRST) || (st_q == ST_STOPREC);
  assign cnt_limit = (st_q == ST_STOPREC) ? (xtal_q ? CW'(STOP_XTAL_CYC) : CW'(STOP_IPO_CYC))
                                          : CW'(RST_CYC);

  rstseq_delay #(.CW(CW)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .en_i    (cnt_en),
    .limit_i (cnt_limit),
    .done_o  (cnt_done)
  );

  assign por_any = por_req_i || bo_req_i;
  // a debugger request is taken once; it must drop before the reset ends
  assign dbg_ok  = dbg_req_i && (st_q != ST_SYSRST);
  assign int_req = por_any || wdt_req_i || dbg_ok;

  always_comb begin
    st_d     = st_q;
    stat_d   = stat_q;
    drv_d    = drv_q;
    xtal_d   = xtal_q;
    dbgclr_d = 1'b0;
    cnt_clr  = 1'b0;
    if (int_req) begin
      st_d     = ST_SYSRST;
      cnt_clr  = 1'b1;
      drv_d    = 1'b1;
      dbgclr_d = dbg_ok;
      if (por_any || dbg_ok)     stat_d = CAUSE_POR;
      else if (st_q != ST_SYSRST) stat_d = '0;
    end else if (ext_trig) begin
      st_d    = ST_SYSRST;
      cnt_clr = 1'b1;
      drv_d   = 1'b0;
      stat_d  = CAUSE_EXT;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          if (stop_wake_i) begin
            st_d    = ST_STOPREC;
            cnt_clr = 1'b1;
            stat_d  = CAUSE_STOP;
            xtal_d  = xtal_en_i;
          end else if (stat_rd_i) begin
            stat_d = '0;
          end
        end
        ST_SYSRST: begin
          if (cnt_done) begin
            if (!drv_q && !pin_s) begin
              st_d = ST_HOLD;
            end else begin
              st_d  = ST_RUN;
              drv_d = 1'b0;
            end
          end
        end
        ST_HOLD: begin
          if (pin_s) st_d = ST_RUN;
        end
        ST_STOPREC: begin
          if (cnt_done) st_d = ST_RUN;
        end
        default: st_d = ST_SYSRST;
      endcase
    end
    vf_d = (st_d == ST_RUN) && (st_q != ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_SYSRST;
      stat_q   <= CAUSE_POR;
      drv_q    <= 1'b1;
      dbgclr_q <= 1'b0;
      vf_q     <= 1'b0;
      xtal_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      stat_q   <= stat_d;
      drv_q    <= drv_d;
      dbgclr_q <= dbgclr_d;
      vf_q     <= vf_d;
      xtal_q   <= xtal_d;
    end
  end

  assign cpu_rst_o       = (st_q != ST_RUN);
  assign sys_rst_o       = (st_q == ST_SYSRST) || (st_q == ST_HOLD);
  assign pin_drive_o     = (st_q == ST_SYSRST) && drv_q;
  assign osc_force_int_o = (st_q == ST_SYSRST) || (st_q == ST_HOLD) || (st_q == ST_STOPREC);
  assign vec_fetch_o     = vf_q;
  assign dbg_clr_o       = dbgclr_q;
  assign stat_o          = stat_q;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int STOP_MAX = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rst_o,
  input logic       sys_rst_o,
  input logic       pin_drive_o,
  input logic       vec_fetch_o,
  input logic       dbg_clr_o,
  input logic [2:0] stat_o
);

  logic [31:0] stop_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stop_run <= '0;
    else if (cpu_rst_o && !sys_rst_o) stop_run <= stop_run + 1'b1;
    else                              stop_run <= '0;
  end

  // R4
  pin_in_sysrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_drive_o |-> (sys_rst_o && cpu_rst_o));

  // R10
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch_o |=> !vec_fetch_o);

  // R10
  fetch_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_o) |-> vec_fetch_o);

  // R5
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_o));

  // R8
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_o && !sys_rst_o) |-> (stat_o == 3'b100 && !pin_drive_o));

  // R8
  stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rst_o && !sys_rst_o) |-> (stop_run < STOP_MAX));

  // R7
  dbg_clr_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clr_o |-> (pin_drive_o && stat_o == 3'b010));

endmodule

bind rstseq_top rstseq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_rst_o   (cpu_rst_o),
  .sys_rst_o   (sys_rst_o),
  .pin_drive_o (pin_drive_o),
  .vec_fetch_o (vec_fetch_o),
  .dbg_clr_o   (dbg_clr_o),
  .stat_o      (stat_o)
);

// File: tb/rstseq_top_test.sv
module rstseq_top_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, ext_low, por_req, bo_req, wdt_req, dbg_req;
  logic       stop_wake, xtal_en, stat_rd, pin_rst_n;
  logic       cpu_rst, sys_rst, pin_drive, osc_force, vec_fetch, dbg_clr;
  logic [2:0] stat;

  // open-drain line: low if either side pulls
  assign pin_rst_n = ~(pin_drive | ext_low);

  rstseq_top uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .pin_rst_n_i     (pin_rst_n),
    .por_req_i       (por_req),
    .bo_req_i        (bo_req),
    .wdt_req_i       (wdt_req),
    .dbg_req_i       (dbg_req),
    .stop_wake_i     (stop_wake),
    .xtal_en_i       (xtal_en),
    .stat_rd_i       (stat_rd),
    .cpu_rst_o       (cpu_rst),
    .sys_rst_o       (sys_rst),
    .pin_drive_o     (pin_drive),
    .osc_force_int_o (osc_force),
    .vec_fetch_o     (vec_fetch),
    .dbg_clr_o       (dbg_clr),
    .stat_o          (stat)
  );

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reset-episode monitor, sampled at falling edges
  int cur_len = 0, cur_drv = 0, cur_sys = 0, cur_osc_bad = 0;
  int last_len = 0, last_drv = 0, last_sys = 0, last_osc_bad = 0, last_vf = 0;
  int rel_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_rst) begin
        cur_len++;
        if (pin_drive) cur_drv++;
        if (sys_rst)   cur_sys++;
        if (!osc_force) cur_osc_bad++;
      end else if (cur_len != 0) begin
        last_len     = cur_len;
        last_drv     = cur_drv;
        last_sys     = cur_sys;
        last_osc_bad = cur_osc_bad;
        last_vf      = int'(vec_fetch);
        cur_len = 0; cur_drv = 0; cur_sys = 0; cur_osc_bad = 0;
        rel_cnt++;
      end
    end
  end

  task automatic wait_release();
    int start;
    start = rel_cnt;
    while (rel_cnt == start) begin
      @(negedge clk);
      #1;
    end
  endtask

  // kind: 0 power-on, 1 brown-out, 2 watchdog, 3 debugger,
  //       4 stop/no crystal, 5 stop/crystal, 6 line low 4, 7 line low 12
  localparam int NV = 8;
  localparam int V_KIND[NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
  localparam int V_LEN [NV] = '{66, 66, 66, 66, 66, 5000, 66, 66};
  localparam int V_STAT[NV] = '{2, 2, 0, 2, 4, 4, 1, 1};
  localparam int V_DRV [NV] = '{1, 1, 1, 1, 0, 0, 0, 0};
  localparam int V_SYS [NV] = '{1, 1, 1, 1, 0, 0, 1, 1};

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual %0d cycles expected completion", 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seen;
    int k;
    logic [2:0] keep;
    rst_n = 1'b0; ext_low = 1'b0; por_req = 1'b0; bo_req = 1'b0; wdt_req = 1'b0;
    dbg_req = 1'b0; stop_wake = 1'b0; xtal_en = 1'b0; stat_rd = 1'b0;

    // R12 state while held in reset
    #5;
    chk(cpu_rst === 1'b1, "R12 cpu_rst in reset", int'(cpu_rst), 1);
    chk(pin_drive === 1'b1, "R12 pin driven in reset", int'(pin_drive), 1);
    chk(stat === 3'b010, "R12 cause in reset", int'(stat), 2);
    chk(vec_fetch === 1'b0, "R12 no fetch in reset", int'(vec_fetch), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_release();
    chk(last_len == 66, "R12 release length", last_len, 66);
    chk(last_drv == 66, "R12 pin drive length", last_drv, 66);

    // table of cause scenarios (R2 R4 R5 R7 R8 R9 R10 R1)
    for (int v = 0; v < NV; v++) begin
      repeat (3) @(negedge clk);
      case (V_KIND[v])
        0: begin por_req = 1'b1; @(negedge clk); por_req = 1'b0; end
        1: begin bo_req  = 1'b1; @(negedge clk); bo_req  = 1'b0; end
        2: begin wdt_req = 1'b1; @(negedge clk); wdt_req = 1'b0; end
        3: begin
          dbg_req = 1'b1;
          seen = 0;
          for (int i = 0; i < 6 && seen == 0; i++) begin
            @(negedge clk);
            if (dbg_clr) seen = 1;
          end
          dbg_req = 1'b0;
          chk(seen == 1, "R7 debugger request cleared", seen, 1);
        end
        4, 5: begin
          xtal_en = (V_KIND[v] == 5);
          stop_wake = 1'b1; @(negedge clk); stop_wake = 1'b0;
        end
        default: begin
          ext_low = 1'b1;
          repeat ((V_KIND[v] == 6) ? 4 : 12) @(negedge clk);
          ext_low = 1'b0;
        end
      endcase
      wait_release();
      chk(last_len == V_LEN[v], "R2 R8 reset length", last_len, V_LEN[v]);
      chk(last_drv == V_DRV[v] * V_LEN[v], "R4 pin drive cycles", last_drv, V_DRV[v] * V_LEN[v]);
      chk(last_sys == V_SYS[v] * V_LEN[v], "R8 system reset cycles", last_sys, V_SYS[v] * V_LEN[v]);
      chk(last_osc_bad == 0, "R9 oscillator forced", last_osc_bad, 0);
      chk(last_vf == 1, "R10 fetch pulse at release", last_vf, 1);
      chk(int'(stat) == V_STAT[v], "R5 R1 cause field", int'(stat), V_STAT[v]);
      @(negedge clk);
      chk(vec_fetch === 1'b0, "R10 fetch one cycle", int'(vec_fetch), 0);
    end

    // R1 three- and two-cycle lows are rejected
    for (int w = 2; w <= 3; w++) begin
      keep = stat;
      @(negedge clk); ext_low = 1'b1;
      repeat (w) @(negedge clk);
      ext_low = 1'b0;
      seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (cpu_rst) seen = 1;
      end
      chk(seen == 0, "R1 short low ignored", seen, 0);
      chk(stat == keep, "R1 cause kept", int'(stat), int'(keep));
    end

    // R11 clear on read
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    chk(stat == 3'b000, "R11 clear on read", int'(stat), 0);

    // R6 simultaneous requests
    @(negedge clk); por_req = 1'b1; wdt_req = 1'b1; dbg_req = 1'b1;
    @(negedge clk); por_req = 1'b0; wdt_req = 1'b0; dbg_req = 1'b0;
    wait_release();
    chk(stat == 3'b010, "R6 power-on priority", int'(stat), 2);
    chk(last_len == 66, "R6 reset length", last_len, 66);

    // R3 line held low past the time-out
    repeat (3) @(negedge clk);
    ext_low = 1'b1;
    repeat (100) @(negedge clk);
    chk(cpu_rst === 1'b1, "R3 held while line low", int'(cpu_rst), 1);
    chk(pin_drive === 1'b0, "R3 line not driven", int'(pin_drive), 0);
    ext_low = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (cpu_rst && k < 10);
    chk(k == 3, "R3 release after line high", k, 3);
    chk(stat == 3'b001, "R3 external cause", int'(stat), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule